// File: doc/BRIEF.md
# Parallel-to-Serial Transmitter with Output-Enable Lane

This block turns parallel words into a serial bit stream for one output pin. Words arrive on a slow clock; the bits leave on a fast clock that is phase-aligned with it. Every rising edge of the slow clock takes one word, and the bits of consecutive words follow one another on the line with no idle slot. In single-rate mode one bit goes out per fast cycle. In double-rate mode two bits go out per fast cycle, one in each clock phase.

A second serializer can be enabled beside the data path. It is four bits wide and runs on the same two clocks. It carries per-bit output-enable information, so a pad driver can be switched to high impedance with single-bit timing. There is no valid/ready handshake and no back-pressure. The stream is isochronous: the source must present a word for every slow-clock cycle, and whatever sits on the inputs at the capturing edge is sent.

The ratio of fast cycles to slow cycles, RATIO, is WIDTH in single-rate mode and WIDTH/2 in double-rate mode. The parameter RATE picks the mode (0 single-rate, 1 double-rate). TRI_EN enables the output-enable lane.

Top module: `pserial_tx`

## Requirements
- R1: In single-rate mode, bit WIDTH-1 of a word is sent first and lower bits follow in descending order, one bit per clk_fast cycle, each held for a whole fast cycle.
- R2: A word captured at a rising clk_slow edge begins on ser_out at the clk_fast rising edge one fast period later. Words follow back to back, each filling exactly RATIO fast cycles.
- R3: In double-rate mode, each fast cycle carries two bits. The higher-order bit is on ser_out while clk_fast is high, and the next bit is there while clk_fast is low.
- R4: Supported widths are 2 to 8 in single-rate mode and 4, 6 or 8 in double-rate mode. Any other width is rejected at elaboration.
- R5: With TRI_EN=1 (allowed only with WIDTH=4), hiz_in is serialized in the same bit order and with the same timing as word_in, so hiz_out bit k accompanies data bit k. hiz_out=1 means high impedance.
- R6: With TRI_EN=0, hiz_out is 0 whenever reset is not applied, and hiz_in has no effect.
- R7: While rst is held, ser_out is 0 and hiz_out is 1 from the second fast cycle of reset onward. After release, these values stay until the first bit of the first captured word is driven; with TRI_EN=0, hiz_out drops to 0 instead.
- R8: word_in and hiz_in are sampled only at rising clk_slow edges, which coincide with rising clk_fast edges. Values present at other times have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Bit clock; rising edges of clk_slow fall on its rising edges |
| clk_slow | input | 1 | Word clock, one cycle per RATIO fast cycles |
| rst | input | 1 | Synchronous reset, active high, sampled in both clock domains |
| word_in | input | WIDTH | Parallel data word, sampled at rising clk_slow |
| hiz_in | input | 4 | Per-bit output-enable word (1 = high impedance), sampled at rising clk_slow |
| ser_out | output | 1 | Serial data, most significant bit first |
| hiz_out | output | 1 | Serial high-impedance control aligned with ser_out |

## Verification
The same fast cycle can carry two events: the last bit of the previous word leaves the shift register, and the next word is loaded. A change of the high-impedance bit can also land at the exact instant that a data bit changes. Both are provoked by streaming a new word at every slow edge, with no idle words. The words are chosen so that the data and enable patterns change at the word seams. A reference deserializer in the bench re-frames both serial outputs every RATIO fast cycles and compares each recovered pair against the words captured. Any dropped, repeated or shifted bit at a seam breaks every frame that follows it.

// File: rtl/pserial_pkg.sv
package pserial_pkg;

  typedef enum logic {
    RATE_SDR = 1'b0,
    RATE_DDR = 1'b1
  } rate_e;

  localparam int HIZ_W = 4;

  function automatic int bits_per_tick(rate_e r);
    return (r == RATE_DDR) ? 2 : 1;
  endfunction

  function automatic bit width_ok(rate_e r, int w);
    if (r == RATE_DDR) return (w == 4) || (w == 6) || (w == 8);
    return (w >= 2) && (w <= 8);
  endfunction

endpackage

// File: rtl/pserial_capture.sv
module pserial_capture #(
  parameter int W  = 4,
  parameter int HW = 4
) (
  input  logic          clk_slow,
  input  logic          rst,
  input  logic [W-1:0]  word_in,
  input  logic [HW-1:0] hiz_in,
  output logic [W-1:0]  word_q,
  output logic [HW-1:0] hiz_q,
  output logic          tick_q
);

  // One capture per word clock; tick_q flips so the bit domain sees a new word.
  always_ff @(posedge clk_slow) begin
    if (rst) begin
      word_q <= '0;
      hiz_q  <= '1;
      tick_q <= 1'b0;
    end else begin
      word_q <= word_in;
      hiz_q  <= hiz_in;
      tick_q <= ~tick_q;
    end
  end

endmodule

// File: rtl/pserial_lane.sv
module pserial_lane #(
  parameter int W    = 4,
  parameter int STEP = 1,
  parameter bit FILL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] par,
  output logic         early,
  output logic         late
);

  localparam int R  = W / STEP;
  localparam int CW = $clog2(R + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] gap_cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= {W{FILL}};
      gap_cnt <= '0;
      armed   <= 1'b0;
    end else if (load) begin
      sh      <= par;
      gap_cnt <= '0;
      armed   <= 1'b1;
    end else begin
      sh <= {sh[W-1-STEP:0], {STEP{FILL}}};
      if (gap_cnt != CW'(R)) gap_cnt <= gap_cnt + CW'(1);
    end
  end

  assign early = sh[W-1];
  assign late  = sh[W-STEP];

  // R1 (and R5 on the enable lane): the captured top bit leads the next cycle.
  p_first_bit_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> (early == $past(par[W-1])));

  // R2: loads arrive exactly R bit-clock cycles apart once streaming.
  p_word_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (load && armed) |-> (gap_cnt == CW'(R - 1)));

  // R7: before the first word after reset the lane shows its idle level.
  p_idle_fill_r7: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (early == FILL));

endmodule

// File: rtl/pserial_ddr_out.sv
module pserial_ddr_out #(
  parameter bit FILL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic early,
  input  logic late,
  output logic pin
);

  logic late_q;

  // The second bit of the pair is re-timed to the falling edge.
  always_ff @(negedge clk) begin
    if (rst) late_q <= FILL;
    else     late_q <= late;
  end

  assign pin = clk ? early : late_q;

  // R3: the low-phase bit is the one the lane presented for this cycle.
  p_late_bit_r3: assert property (@(posedge clk) disable iff (rst)
    late_q == late);

endmodule

// File: rtl/pserial_tx.sv
module pserial_tx #(
  parameter int                 WIDTH  = 4,
  parameter pserial_pkg::rate_e RATE   = pserial_pkg::RATE_SDR,
  parameter bit                 TRI_EN = 1'b1
) (
  input  logic                          clk_fast,
  input  logic                          clk_slow,
  input  logic                          rst,
  input  logic [WIDTH-1:0]              word_in,
  input  logic [pserial_pkg::HIZ_W-1:0] hiz_in,
  output logic                          ser_out,
  output logic                          hiz_out
);
  import pserial_pkg::*;

  localparam int STEP = bits_per_tick(RATE);
  localparam int HW   = HIZ_W;

  // R4, R5: reject unsupported widths and an enable lane with a mismatched width.
  if (!width_ok(RATE, WIDTH) || (TRI_EN && (WIDTH != HW))) begin : g_bad_cfg
    $error("pserial_tx: unsupported WIDTH/RATE/TRI_EN combination");
  end

  logic [WIDTH-1:0] word_q;
  logic [HW-1:0]    hiz_q;
  logic             tick_q;
  logic             seen_q;
  logic             load;
  logic             d_early, d_late, t_early, t_late;

  pserial_capture #(.W(WIDTH), .HW(HW)) u_capture (
    .clk_slow (clk_slow),
    .rst      (rst),
    .word_in  (word_in),
    .hiz_in   (hiz_in),
    .word_q   (word_q),
    .hiz_q    (hiz_q),
    .tick_q   (tick_q)
  );

  // R8: the coincident edge still sees the old tick, so the load lands one fast cycle later.
  always_ff @(posedge clk_fast) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= tick_q;
  end
  assign load = tick_q ^ seen_q;

  pserial_lane #(.W(WIDTH), .STEP(STEP), .FILL(1'b0)) u_data_lane (
    .clk   (clk_fast),
    .rst   (rst),
    .load  (load),
    .par   (word_q),
    .early (d_early),
    .late  (d_late)
  );

  if (TRI_EN) begin : g_hiz_lane
    pserial_lane #(.W(HW), .STEP(STEP), .FILL(1'b1)) u_hiz_lane (
      .clk   (clk_fast),
      .rst   (rst),
      .load  (load),
      .par   (hiz_q),
      .early (t_early),
      .late  (t_late)
    );
  end else begin : g_hiz_off
    logic hiz_idle_q;
    logic unused_hiz;
    always_ff @(posedge clk_fast) hiz_idle_q <= rst;
    assign t_early    = hiz_idle_q;
    assign t_late     = hiz_idle_q;
    assign unused_hiz = ^hiz_q;
  end

  if (RATE == RATE_DDR) begin : g_ddr
    pserial_ddr_out #(.FILL(1'b0)) u_data_out (
      .clk (clk_fast), .rst (rst), .early (d_early), .late (d_late), .pin (ser_out)
    );
    pserial_ddr_out #(.FILL(1'b1)) u_hiz_out (
      .clk (clk_fast), .rst (rst), .early (t_early), .late (t_late), .pin (hiz_out)
    );
  end else begin : g_sdr
    logic unused_late;
    assign ser_out     = d_early;
    assign hiz_out     = t_early;
    assign unused_late = d_late ^ t_late;
  end

endmodule

// File: tb/pserial_tx_test.sv
module pserial_tx_rig #(
  parameter int                 W    = 4,
  parameter pserial_pkg::rate_e RATE = pserial_pkg::RATE_SDR,
  parameter bit                 TRI  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  output int   errs,
  output int   checks,
  output int   words
);
  localparam bit DDR   = (RATE == pserial_pkg::RATE_DDR);
  localparam int R     = DDR ? W / 2 : W;
  localparam int START = 2 % R;
  localparam int NV    = 16;
  // {enable nibble, data byte}; low W data bits are used
  localparam logic [11:0] VEC [NV] = '{
    12'h000, 12'hFFF, 12'hAAA, 12'h555, 12'h180, 12'h801, 12'h0FF, 12'hF00,
    12'h3C3, 12'hC3C, 12'h696, 12'h969, 12'h27E, 12'h481, 12'hE5A, 12'h7A5
  };

  logic         cd = 1'b0;
  int           ph = 0;
  int           vi = 0;
  logic [W-1:0] din = '0;
  logic [3:0]   hin = 4'hF;
  logic         ser, hiz;
  logic [W-1:0] expd [64];
  logic [3:0]   exph [64];
  int           wr = 0, rd = 0, nb = 0, rcnt = 0;
  bit           armed = 0, in_fr = 0, started = 0;
  logic [W-1:0] acc, tacc;
  int           err_a = 0, chk_a = 0, err_b = 0, chk_b = 0, nw = 0;

  assign errs   = err_a + err_b;
  assign checks = chk_a + chk_b;
  assign words  = nw;

  pserial_tx #(.WIDTH(W), .RATE(RATE), .TRI_EN(TRI)) uut (
    .clk_fast (clk),
    .clk_slow (cd),
    .rst      (rst),
    .word_in  (din),
    .hiz_in   (hin),
    .ser_out  (ser),
    .hiz_out  (hiz)
  );

  // Word clock in phase with the bit clock; record what the capture edge sees.
  always @(posedge clk) begin
    if (rst) begin
      wr = 0; rd = 0; armed = 0;
    end
    if (ph == 0) begin
      cd = 1'b1;
      if (!rst) begin
        expd[wr % 64] = din;
        exph[wr % 64] = hin;
        wr++;
        armed = 1;
        vi = (vi + 1) % NV;
      end
    end else if (ph == R / 2) begin
      cd = 1'b0;
    end
    ph = (ph + 1) % R;
  end

  // R8: inputs hold a clean word only in the last fast cycle before a word edge.
  always @(negedge clk) begin
    if (ph == 0) begin
      din = VEC[vi][W-1:0];
      hin = VEC[vi][11:8];
    end else begin
      din = ~VEC[vi][W-1:0];
      hin = ~VEC[vi][11:8];
    end
  end

  task automatic take(input bit first);
    logic [W-1:0] d_e, t_e;
    if (rst) begin
      in_fr = 0; started = 0;
      return;
    end
    if (first && armed && ph == START) begin
      in_fr = 1; started = 1; nb = 0;
    end
    if (!started) begin
      chk_a++;
      if (ser !== 1'b0 || hiz !== TRI) begin
        err_a++;
        $display("FAIL R7 idle after reset: ser=%b hiz=%b expected ser=0 hiz=%b", ser, hiz, TRI);
      end
    end else if (in_fr) begin
      acc  = {acc[W-2:0], ser};
      tacc = {tacc[W-2:0], hiz};
      nb++;
      if (nb == W) begin
        in_fr = 0;
        chk_a++;
        if (rd == wr) begin
          err_a++;
          $display("FAIL R2 frame with no captured word: got %h expected none", acc);
        end else begin
          d_e = expd[rd % 64];
          t_e = TRI ? W'(exph[rd % 64]) : '0;
          rd++;
          nw++;
          chk_a++;
          if (acc !== d_e) begin
            err_a++;
            $display("FAIL %s data word %0d (W=%0d): got %h expected %h",
                     DDR ? "R3 R4 R8" : "R1 R2 R4 R8", nw, W, acc, d_e);
          end
          if (tacc !== t_e) begin
            err_a++;
            $display("FAIL %s enable word %0d (W=%0d): got %h expected %h",
                     TRI ? "R5" : "R6", nw, W, tacc, t_e);
          end
        end
      end
    end
  endtask

  // Reference deserializer: one sample per phase, away from the edges.
  always @(posedge clk) begin
    #5 take(1'b1);
    if (DDR) begin
      #10 take(1'b0);
    end
  end

  // R7: outputs while reset is held.
  always @(negedge clk) begin
    #2;
    if (rst) begin
      rcnt++;
      if (rcnt >= 2) begin
        chk_b++;
        if (ser !== 1'b0 || hiz !== 1'b1) begin
          err_b++;
          $display("FAIL R7 during reset: ser=%b hiz=%b expected ser=0 hiz=1", ser, hiz);
        end
      end
    end else begin
      rcnt = 0;
    end
  end

endmodule

module pserial_tx_test;
  import pserial_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int  e4, c4, w4, e7, c7, w7, ed, cdd, wdd;
  int  t_err = 0, t_chk = 0;
  bit  done = 0;

  pserial_tx_rig #(.W(4), .RATE(RATE_SDR), .TRI(1'b1)) rig_s4 (
    .clk (clk), .rst (rst), .errs (e4), .checks (c4), .words (w4));
  pserial_tx_rig #(.W(7), .RATE(RATE_SDR), .TRI(1'b0)) rig_s7 (
    .clk (clk), .rst (rst), .errs (e7), .checks (c7), .words (w7));
  pserial_tx_rig #(.W(4), .RATE(RATE_DDR), .TRI(1'b1)) rig_d4 (
    .clk (clk), .rst (rst), .errs (ed), .checks (cdd), .words (wdd));

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks",
               t_err + e4 + e7 + ed, t_chk + c4 + c7 + cdd);
      $finish;
    end
  endtask

  task automatic check_words(input string name, input int got, input int minw);
    t_chk++;
    if (got < minw) begin
      t_err++;
      $display("FAIL R2 %s recovered words: got %0d expected at least %0d", name, got, minw);
    end
  endtask

  initial begin
    repeat (20) @(negedge clk);
    #3 rst = 1'b0;
    repeat (400) @(negedge clk);
    // directed: reset in the middle of a stream, then resume
    #3 rst = 1'b1;
    repeat (30) @(negedge clk);
    #3 rst = 1'b0;
    repeat (400) @(negedge clk);
    check_words("sdr w4", w4, 150);
    check_words("sdr w7", w7, 90);
    check_words("ddr w4", wdd, 300);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    t_chk++;
    t_err++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

endmodule